// File: doc/BRIEF.md
# Table-Driven Pedestrian Crossing Controller

This block runs a push-button crossing light. A five-bit state register and the sampled level of the crossing button together form a six-bit address. That address selects one word of a 64-word lookup table. Each word holds the next state and the three lamp bits (green, yellow, red). All sequencing comes from the table contents; there is no hand-written next-state logic. The state moves only when a one-second tick enable is high.

The address register loads on the rising clock edge. The lamp register loads on the falling edge, so the outputs never show a value while the table lookup is settling. A parameter can place both registers on the rising edge instead. In that case the lamps lag by half a clock more. An asynchronous power-up reset returns the controller to the idle green state.

The button is active low and is not debounced. It is seen only on the clock edge that carries a tick, so a press shorter than one tick can be missed. A press during the red phase sends the sequence back to the start of the red timing.

Top module: `xwalk_ctrl`

## Requirements
- R1: Asserting `rst` (active high, asynchronous) immediately forces green on and yellow and red off, and returns the controller to state 0 with the button treated as released.
- R2: In state 0 with `btn_n` high on a tick, the controller stays in state 0 with only green lit.
- R3: In state 0 with `btn_n` low (pressed) on a tick, yellow lights for that tick and the next state is 1.
- R4: Yellow stays lit for seven ticks in total: the press tick plus states 1 to 6. In these states the state advances by one per tick whatever the button does.
- R5: State 7 and every state above it light red. Red lasts 25 ticks (states 7 to 31). On the tick after state 31, with the button released, the controller is back in state 0 with green.
- R6: A press on a tick in any state from 8 to 31 keeps red lit and makes the next state 7. The full 25-tick red window then runs again before green returns.
- R7: The state and lamps change only on a clock edge where `tick` is high. Button activity between ticks has no effect.
- R8: Exactly one lamp is lit at all times.
- R9: With the default phase setting, the lamps take their new value on the falling clock edge that follows the rising edge where the tick was sampled. Between those two edges the lamps keep their previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous power-up reset, active high |
| tick | input | 1 | One-second step enable, one clock wide |
| btn_n | input | 1 | Crossing button, low when pressed |
| green_o | output | 1 | Green lamp |
| yellow_o | output | 1 | Yellow lamp |
| red_o | output | 1 | Red lamp |

## Verification
The bench drives the controller with several button patterns:
- An unpressed idle run, which separates staying in green from drifting into the cycle.
- One press followed by a free-running cycle, which checks the length of each lamp phase.
- Presses during yellow, which must not change the timing.
- Presses early in red and in the very last red state, which must each restart the red window rather than end it.
- A button held low with no tick, which shows that only ticked edges are sampled.
- A probe taken between the rising and falling edges, which shows the half-cycle output phase.
- A mid-sequence asynchronous reset.

// File: rtl/xwalk_pkg.sv
`timescale 1ns/1ps
package xwalk_pkg;
   // Lamp field order inside a table word: {green, yellow, red}
   localparam int LAMP_W = 3;
   typedef enum logic [LAMP_W-1:0] {
      LAMP_GREEN  = 3'b100,
      LAMP_YELLOW = 3'b010,
      LAMP_RED    = 3'b001
   } lamp_e;
endpackage

// File: rtl/xwalk_table.sv
`timescale 1ns/1ps
// Combinational lookup: address {state, button level} -> {next state, lamps}
module xwalk_table
   import xwalk_pkg::*;
#(
   parameter int STATE_W   = 5,
   parameter int RED_ENTRY = 7,
   localparam int ADDR_W   = STATE_W + 1,
   localparam int WORD_W   = STATE_W + LAMP_W
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [WORD_W-1:0] word
);
   localparam logic [STATE_W-1:0] ST_IDLE  = '0;
   localparam logic [STATE_W-1:0] ST_LAST  = '1;
   localparam logic [STATE_W-1:0] ST_ENTRY = STATE_W'(RED_ENTRY);
   localparam logic [STATE_W-1:0] ST_ONE   = STATE_W'(1);

   logic [STATE_W-1:0] cur;
   logic               released;
   logic [STATE_W-1:0] nxt;
   lamp_e              lamp;

   assign cur      = addr[ADDR_W-1:1];
   assign released = addr[0];

   always_comb begin
      nxt  = cur + ST_ONE;
      lamp = LAMP_RED;
      if (cur == ST_IDLE) begin
         if (released) begin
            nxt  = ST_IDLE;
            lamp = LAMP_GREEN;
         end else begin
            nxt  = ST_ONE;
            lamp = LAMP_YELLOW;
         end
      end else if (cur < ST_ENTRY) begin
         lamp = LAMP_YELLOW;
      end else if (cur == ST_ENTRY) begin
         lamp = LAMP_RED;
      end else if (!released) begin
         nxt  = ST_ENTRY;
         lamp = LAMP_RED;
      end else if (cur == ST_LAST) begin
         nxt  = ST_IDLE;
         lamp = LAMP_RED;
      end
   end

   assign word = {nxt, lamp};
endmodule

// File: rtl/xwalk_addr_reg.sv
`timescale 1ns/1ps
// Rising-edge address register: holds {state, button level}
module xwalk_addr_reg #(
   parameter int STATE_W = 5,
   localparam int ADDR_W = STATE_W + 1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               tick,
   input  logic               btn_n,
   input  logic [STATE_W-1:0] nxt_state,
   output logic [ADDR_W-1:0]  addr_q
);
   always_ff @(posedge clk or posedge rst) begin
      if (rst)       addr_q <= {{STATE_W{1'b0}}, 1'b1};
      else if (tick) addr_q <= {nxt_state, btn_n};
   end
endmodule

// File: rtl/xwalk_out_reg.sv
`timescale 1ns/1ps
// Lamp register; OPPOSITE_PHASE selects falling-edge or rising-edge capture
module xwalk_out_reg #(
   parameter int           WIDTH          = 3,
   parameter bit           OPPOSITE_PHASE = 1'b1,
   parameter logic [WIDTH-1:0] RESET_VAL  = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (OPPOSITE_PHASE) begin : g_fall
         always_ff @(negedge clk or posedge rst) begin
            if (rst) q <= RESET_VAL;
            else     q <= d;
         end
      end else begin : g_rise
         always_ff @(posedge clk or posedge rst) begin
            if (rst) q <= RESET_VAL;
            else     q <= d;
         end
      end
   endgenerate
endmodule

// File: rtl/xwalk_ctrl.sv
`timescale 1ns/1ps
module xwalk_ctrl
   import xwalk_pkg::*;
#(
   parameter int STATE_W        = 5,
   parameter int RED_ENTRY      = 7,
   parameter bit OPPOSITE_PHASE = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic tick,
   input  logic btn_n,
   output logic green_o,
   output logic yellow_o,
   output logic red_o
);
   localparam int ADDR_W = STATE_W + 1;
   localparam int WORD_W = STATE_W + LAMP_W;

   generate
      if (STATE_W < 2 || STATE_W > 10) begin : g_bad_width
         $error("xwalk_ctrl: STATE_W out of range");
      end
      if (RED_ENTRY < 2 || RED_ENTRY > (1 << STATE_W) - 2) begin : g_bad_entry
         $error("xwalk_ctrl: RED_ENTRY must leave room for yellow and red states");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic [WORD_W-1:0] word;
   logic [LAMP_W-1:0] lamp_q;

   xwalk_table #(.STATE_W(STATE_W), .RED_ENTRY(RED_ENTRY)) u_table (
      .addr (addr_q),
      .word (word)
   );

   xwalk_addr_reg #(.STATE_W(STATE_W)) u_addr (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .btn_n     (btn_n),
      .nxt_state (word[WORD_W-1:LAMP_W]),
      .addr_q    (addr_q)
   );

   xwalk_out_reg #(
      .WIDTH          (LAMP_W),
      .OPPOSITE_PHASE (OPPOSITE_PHASE),
      .RESET_VAL      (LAMP_GREEN)
   ) u_out (
      .clk (clk),
      .rst (rst),
      .d   (word[LAMP_W-1:0]),
      .q   (lamp_q)
   );

   assign {green_o, yellow_o, red_o} = lamp_q;
endmodule

// File: rtl/xwalk_ctrl_chk.sv
`timescale 1ns/1ps
module xwalk_ctrl_chk #(
   parameter int STATE_W        = 5,
   parameter int RED_ENTRY      = 7,
   parameter bit OPPOSITE_PHASE = 1'b1,
   localparam int ADDR_W        = STATE_W + 1
) (
   input logic              clk,
   input logic              rst,
   input logic              tick,
   input logic [ADDR_W-1:0] addr_q,
   input logic [2:0]        lamps
);
   logic [STATE_W-1:0] st;
   assign st = addr_q[ADDR_W-1:1];

   AST_ONE_LAMP: assert property (@(posedge clk) disable iff (rst)
      $countones(lamps) == 1); // R8
   AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(addr_q)); // R7
   AST_IDLE_PRESS: assert property (@(posedge clk) disable iff (rst)
      (tick && st == '0 && !addr_q[0]) |=> st == STATE_W'(1)); // R3
   AST_YELLOW_STEP: assert property (@(posedge clk) disable iff (rst)
      (tick && st != '0 && st < STATE_W'(RED_ENTRY)) |=> st == $past(st) + STATE_W'(1)); // R4
   AST_WRAP_GREEN: assert property (@(posedge clk) disable iff (rst)
      (tick && st == '1 && addr_q[0]) |=> st == '0); // R5
   AST_RED_RESTART: assert property (@(posedge clk) disable iff (rst)
      (tick && st > STATE_W'(RED_ENTRY) && !addr_q[0]) |=> st == STATE_W'(RED_ENTRY)); // R6

   generate
      if (OPPOSITE_PHASE) begin : g_phase
         AST_GREEN_IDLE: assert property (@(posedge clk) disable iff (rst)
            lamps[2] |-> (st == '0 && addr_q[0])); // R2
      end
   endgenerate
endmodule

bind xwalk_ctrl xwalk_ctrl_chk #(
   .STATE_W(STATE_W), .RED_ENTRY(RED_ENTRY), .OPPOSITE_PHASE(OPPOSITE_PHASE)
) u_chk (
   .clk    (clk),
   .rst    (rst),
   .tick   (tick),
   .addr_q (addr_q),
   .lamps  ({green_o, yellow_o, red_o})
);

// File: tb/tb_xwalk_ctrl.sv
`timescale 1ns/1ps
module tb_xwalk_ctrl;
   localparam logic [2:0] G = 3'b100;
   localparam logic [2:0] Y = 3'b010;
   localparam logic [2:0] R = 3'b001;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tick = 1'b0;
   logic btn_n = 1'b1;
   logic green_o, yellow_o, red_o;
   int   n_checks = 0;
   int   n_fails  = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   xwalk_ctrl dut (
      .clk(clk), .rst(rst), .tick(tick), .btn_n(btn_n),
      .green_o(green_o), .yellow_o(yellow_o), .red_o(red_o)
   );

   function automatic logic [2:0] lamps();
      return {green_o, yellow_o, red_o};
   endfunction

   // k = ticks since the press tick, no further presses
   function automatic logic [2:0] exp_k(int k);
      if (k <= 6)  return Y;
      if (k <= 31) return R;
      return G;
   endfunction

   task automatic check(string req, logic [2:0] got, logic [2:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s: lamps got %b expected %b at %0t", req, got, exp, $time);
      end
      n_checks++;
      if ($countones(got) != 1) begin
         n_fails++;
         $display("FAIL R8: lamps got %b expected one-hot", got);
      end
   endtask

   task automatic tick_once(logic b);
      @(posedge clk); #2;
      btn_n = b; tick = 1'b1;
      @(posedge clk); #2;
      tick = 1'b0; btn_n = 1'b1;
      @(negedge clk); #2;
   endtask

   task automatic advance(int from_k, int to_k, string req);
      for (int k = from_k; k <= to_k; k++) begin
         tick_once(1'b1);
         check(req, lamps(), exp_k(k));
      end
   endtask

   task automatic t_reset();
      check("R1 reset", lamps(), G);
      @(negedge clk); rst = 1'b0;
      #2 check("R1 after release", lamps(), G);
   endtask

   task automatic t_idle();
      for (int i = 0; i < 3; i++) begin
         tick_once(1'b1);
         check("R2 idle", lamps(), G);
      end
   endtask

   task automatic t_full_cycle();
      tick_once(1'b0);
      check("R3 press", lamps(), Y);
      advance(1, 6, "R4 yellow");
      advance(7, 31, "R5 red");
      advance(32, 32, "R5 back to green");
   endtask

   task automatic t_press_in_yellow();
      tick_once(1'b0);
      check("R3 press", lamps(), Y);
      advance(1, 2, "R4 yellow");
      tick_once(1'b0);
      check("R4 press ignored", lamps(), Y);
      advance(4, 6, "R4 yellow");
      advance(7, 32, "R4 timing unchanged");
   endtask

   task automatic t_restart_early();
      tick_once(1'b0);
      advance(1, 10, "R6 lead-in");
      tick_once(1'b0);
      check("R6 press in red", lamps(), R);
      advance(7, 31, "R6 red rerun");
      advance(32, 32, "R6 green after rerun");
   endtask

   task automatic t_restart_last();
      tick_once(1'b0);
      advance(1, 30, "R6 lead-in");
      tick_once(1'b0);
      check("R6 press at last red", lamps(), R);
      advance(7, 32, "R6 rerun from last");
   endtask

   task automatic t_no_tick();
      btn_n = 1'b0;
      for (int i = 0; i < 10; i++) @(posedge clk);
      #2 btn_n = 1'b1;
      @(negedge clk); #2;
      check("R7 press without tick", lamps(), G);
      tick_once(1'b1);
      check("R7 still idle", lamps(), G);
   endtask

   task automatic t_phase();
      @(posedge clk); #2;
      btn_n = 1'b0; tick = 1'b1;
      @(posedge clk); #2;
      tick = 1'b0; btn_n = 1'b1;
      check("R9 before falling edge", lamps(), G);
      @(negedge clk); #2;
      check("R9 after falling edge", lamps(), Y);
      advance(1, 32, "R9 cycle completes");
   endtask

   task automatic t_async_reset();
      tick_once(1'b0);
      advance(1, 12, "R1 lead-in");
      #3 rst = 1'b1;
      #2 check("R1 async reset", lamps(), G);
      @(negedge clk); #2 rst = 1'b0;
      tick_once(1'b1);
      check("R1 idle after reset", lamps(), G);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
   endtask

   initial begin
      #25;
      t_reset();
      t_idle();
      t_full_cycle();
      t_press_in_yellow();
      t_restart_early();
      t_restart_last();
      t_no_tick();
      t_phase();
      t_async_reset();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not finish, got timeout expected completion");
         summary();
         $finish;
      end
   end
endmodule